// File: doc/BRIEF.md
# Control Transfer Privilege Checker

This block rules on whether a far control transfer is allowed. A far transfer is one that loads a new code selector. The block takes the kind of operation and the type of the referenced descriptor. It also takes the conforming attribute of the target code segment and four privilege levels:

- the current level,
- the requested level carried by the selector,
- the privilege of the referenced gate or task descriptor,
- the privilege of the target code segment.

Privilege levels are 2-bit numbers, and 0 is the most privileged.

An execution pipeline strobes one request per cycle. One cycle later it gets a registered verdict with a done pulse. The verdict is either allow or fault, and a fault carries a fixed protection-fault vector. With an allowed verdict the block also gives the privilege level the transfer lands at, and whether the interrupt-enable flag has to be cleared.

Fetching the descriptor, switching stacks and copying parameters are left to the surrounding logic.

Top module: `ctp_checker`

## Requirements
- R1: After reset, done_o, allow_o, fault_o, clear_if_o, vector_o and new_cpl_o are all zero. A request with valid_i high at a rising edge produces done_o high for exactly the following cycle, with the verdict registered at that same edge.
- R2: Operation codes are JMP=0, CALL=1, RET=2, IRET=3, software interrupt=4, exception=5, external interrupt=6, reserved=7. Descriptor codes are null=0, code=1, call gate=2, interrupt gate=3, trap gate=4, task gate=5, task state=6, reserved=7. The legal pairings are:
  - JMP with code, task gate or task state;
  - CALL with code, call gate, task gate or task state;
  - RET and IRET with code only;
  - the three interrupt kinds with interrupt gate, trap gate or task gate.
  Any other pairing, including every null or reserved code, faults.
- R3: A direct transfer to a non-conforming code segment is allowed only when the target privilege equals the current level.
- R4: A direct transfer to a conforming code segment is allowed when the target privilege is numerically at most the current level. The landing level stays the current level.
- R5: A transfer through any gate or task state descriptor faults unless max(current level, requested level) is numerically at most that descriptor's privilege.
- R6: A transfer through a call, interrupt or trap gate faults when the target privilege is numerically greater than the current level.
- R7: clear_if_o is 1 only for an allowed transfer through an interrupt gate. An allowed transfer through a trap gate leaves clear_if_o at 0.
- R8: new_cpl_o equals the target privilege for an allowed transfer through a call, interrupt or trap gate to a non-conforming segment. In every other case it equals the current level.
- R9: For task gate and task state transfers the target privilege input has no effect on the verdict.
- R10: A fault gives allow_o=0, fault_o=1, vector_o=13 and clear_if_o=0. An allowed verdict gives vector_o=0.
- R11: While valid_i is low, all verdict outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| desc_i | input | 3 | Referenced descriptor type code |
| conforming_i | input | 1 | Target code segment is conforming |
| cpl_i | input | 2 | Current privilege level |
| rpl_i | input | 2 | Requested privilege level of the selector |
| gate_dpl_i | input | 2 | Privilege of the referenced gate or task descriptor |
| target_dpl_i | input | 2 | Privilege of the target code segment |
| done_o | output | 1 | Verdict valid pulse |
| allow_o | output | 1 | Transfer allowed |
| fault_o | output | 1 | Transfer rejected |
| vector_o | output | 8 | Exception vector, 13 on fault, 0 otherwise |
| clear_if_o | output | 1 | Interrupt-enable flag must be cleared |
| new_cpl_o | output | 2 | Privilege level after the transfer |

## Verification
Two functions can meet in one verdict, and the bench provokes both cases.

The first case combines privilege elevation with interrupt masking. An interrupt strobed through an interrupt gate to a more privileged non-conforming segment has to raise clear_if_o and lower new_cpl_o in the same done cycle. Directed requests cover this, both at the edge where max(current, requested) equals the gate privilege and one step past it. Randomized requests then sweep all level combinations.

The second case combines a pairing violation with a failing privilege comparison. The bench checks that this yields one fault with vector 13 and the unchanged level. A bench model scores each verdict, and it is written from the requirements alone.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int PL_W = 2;
  localparam int OP_W = 3;
  localparam int DT_W = 3;

  typedef logic [PL_W-1:0] pl_t;

  typedef enum logic [OP_W-1:0] {
    OP_JMP    = 3'd0,
    OP_CALL   = 3'd1,
    OP_RET    = 3'd2,
    OP_IRET   = 3'd3,
    OP_SWINT  = 3'd4,
    OP_EXC    = 3'd5,
    OP_EXTINT = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef enum logic [DT_W-1:0] {
    DT_NULL  = 3'd0,
    DT_CODE  = 3'd1,
    DT_CGATE = 3'd2,
    DT_IGATE = 3'd3,
    DT_TGATE = 3'd4,
    DT_TASKG = 3'd5,
    DT_TSS   = 3'd6,
    DT_RSVD  = 3'd7
  } dt_e;

  // Path class derived from the descriptor type.
  typedef enum logic [1:0] {
    PATH_DIRECT = 2'd0,
    PATH_GATE   = 2'd1,
    PATH_TASK   = 2'd2,
    PATH_NONE   = 2'd3
  } path_e;

  // Numerically larger level is the less privileged one.
  function automatic pl_t weaker_level(input pl_t a, input pl_t b);
    return (a > b) ? a : b;
  endfunction

  // True when level a is at least as privileged as level b.
  function automatic logic as_strong(input pl_t a, input pl_t b);
    return a <= b;
  endfunction

  // Bit mask of descriptor codes an operation may reference.
  function automatic logic [(1<<DT_W)-1:0] legal_mask(input op_e op);
    logic [(1<<DT_W)-1:0] m;
    m = '0;
    unique case (op)
      OP_JMP:  begin m[DT_CODE] = 1'b1; m[DT_TASKG] = 1'b1; m[DT_TSS] = 1'b1; end
      OP_CALL: begin
        m[DT_CODE] = 1'b1; m[DT_CGATE] = 1'b1;
        m[DT_TASKG] = 1'b1; m[DT_TSS] = 1'b1;
      end
      OP_RET, OP_IRET: m[DT_CODE] = 1'b1;
      OP_SWINT, OP_EXC, OP_EXTINT: begin
        m[DT_IGATE] = 1'b1; m[DT_TGATE] = 1'b1; m[DT_TASKG] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ctp_pair_dec.sv
module ctp_pair_dec
  import ctp_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [DT_W-1:0] desc_i,
  output logic            pair_ok_o,
  output path_e           path_o,
  output logic            int_gate_o
);
  localparam int NDT = 1 << DT_W;

  logic [NDT-1:0] mask;
  logic [NDT-1:0] hit;

  assign mask = legal_mask(op_e'(op_i));

  // One match line per descriptor code.
  for (genvar g = 0; g < NDT; g++) begin : g_hit
    assign hit[g] = mask[g] && (desc_i == DT_W'(g));
  end

  assign pair_ok_o  = |hit;
  assign int_gate_o = (desc_i == DT_IGATE);

  always_comb begin
    unique case (dt_e'(desc_i))
      DT_CODE:                     path_o = PATH_DIRECT;
      DT_CGATE, DT_IGATE, DT_TGATE: path_o = PATH_GATE;
      DT_TASKG, DT_TSS:            path_o = PATH_TASK;
      default:                     path_o = PATH_NONE;
    endcase
  end
endmodule

// File: rtl/ctp_priv_eval.sv
module ctp_priv_eval
  import ctp_pkg::*;
(
  input  path_e     path_i,
  input  logic      conforming_i,
  input  pl_t       cpl_i,
  input  pl_t       rpl_i,
  input  pl_t       gate_dpl_i,
  input  pl_t       target_dpl_i,
  output logic      gate_ok_o,
  output logic      target_ok_o,
  output logic      priv_ok_o,
  output pl_t       next_cpl_o
);
  pl_t eff_level;
  logic direct_ok;

  assign eff_level   = weaker_level(cpl_i, rpl_i);
  assign gate_ok_o   = as_strong(eff_level, gate_dpl_i);
  assign target_ok_o = as_strong(target_dpl_i, cpl_i);
  assign direct_ok   = conforming_i ? as_strong(target_dpl_i, cpl_i)
                                    : (target_dpl_i == cpl_i);

  always_comb begin
    priv_ok_o  = 1'b0;
    next_cpl_o = cpl_i;
    unique case (path_i)
      PATH_DIRECT: priv_ok_o = direct_ok;
      PATH_GATE: begin
        priv_ok_o = gate_ok_o && target_ok_o;
        if (!conforming_i) next_cpl_o = target_dpl_i;
      end
      PATH_TASK: priv_ok_o = gate_ok_o;
      default:   priv_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker
  import ctp_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [2:0]       desc_i,
  input  logic             conforming_i,
  input  logic [1:0]       cpl_i,
  input  logic [1:0]       rpl_i,
  input  logic [1:0]       gate_dpl_i,
  input  logic [1:0]       target_dpl_i,
  output logic             done_o,
  output logic             allow_o,
  output logic             fault_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             clear_if_o,
  output logic [1:0]       new_cpl_o
);
  localparam logic [VEC_W-1:0] FVEC = VEC_W'(FAULT_VEC);

  // Named internal events.
  logic  pair_ok;
  path_e path;
  logic  int_gate;
  logic  gate_ok;
  logic  target_ok;
  logic  priv_ok;
  pl_t   next_cpl;
  logic  pass;
  logic  uses_gate_check;

  ctp_pair_dec u_pair (
    .op_i      (op_i),
    .desc_i    (desc_i),
    .pair_ok_o (pair_ok),
    .path_o    (path),
    .int_gate_o(int_gate)
  );

  ctp_priv_eval u_priv (
    .path_i      (path),
    .conforming_i(conforming_i),
    .cpl_i       (cpl_i),
    .rpl_i       (rpl_i),
    .gate_dpl_i  (gate_dpl_i),
    .target_dpl_i(target_dpl_i),
    .gate_ok_o   (gate_ok),
    .target_ok_o (target_ok),
    .priv_ok_o   (priv_ok),
    .next_cpl_o  (next_cpl)
  );

  assign pass            = pair_ok && priv_ok;
  assign uses_gate_check = (path == PATH_GATE) || (path == PATH_TASK);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      allow_o    <= 1'b0;
      fault_o    <= 1'b0;
      vector_o   <= '0;
      clear_if_o <= 1'b0;
      new_cpl_o  <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        allow_o    <= pass;
        fault_o    <= !pass;
        vector_o   <= pass ? '0 : FVEC;
        clear_if_o <= pass && int_gate;
        new_cpl_o  <= pass ? next_cpl : cpl_i;
      end
    end
  end

  // Assertions
  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  assert_no_spurious_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  assert_bad_pair_faults_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pair_ok |=> fault_o && !allow_o && vector_o == FVEC);
  assert_gate_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && uses_gate_check && !gate_ok |=> fault_o);
  assert_gate_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && path == PATH_GATE && !target_ok |=> fault_o);
  assert_clear_if_only_allowed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_if_o |-> allow_o);
  assert_fault_keeps_cpl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> new_cpl_o == $past(cpl_i) && !clear_if_o);
  assert_cpl_never_weakens_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> new_cpl_o <= $past(cpl_i));
  assert_hold_when_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(allow_o) && $stable(fault_o) && $stable(vector_o)
                 && $stable(clear_if_o) && $stable(new_cpl_o));
endmodule

// File: tb/ctp_checker_tb_top.sv
`timescale 1ns/1ps
module ctp_checker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] op = '0;
  logic [2:0] desc = '0;
  logic       conf = 1'b0;
  logic [1:0] cpl = '0, rpl = '0, gdpl = '0, tdpl = '0;
  logic       done, allow, fault, clr_if;
  logic [7:0] vec;
  logic [1:0] ncpl;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  ctp_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .desc_i(desc),
    .conforming_i(conf), .cpl_i(cpl), .rpl_i(rpl), .gate_dpl_i(gdpl),
    .target_dpl_i(tdpl), .done_o(done), .allow_o(allow), .fault_o(fault),
    .vector_o(vec), .clear_if_o(clr_if), .new_cpl_o(ncpl)
  );

  // Bench model written from the requirements.
  function automatic bit m_pair(input logic [2:0] o, input logic [2:0] d);
    case (o)
      3'd0: return d == 3'd1 || d == 3'd5 || d == 3'd6;
      3'd1: return d == 3'd1 || d == 3'd2 || d == 3'd5 || d == 3'd6;
      3'd2, 3'd3: return d == 3'd1;
      3'd4, 3'd5, 3'd6: return d == 3'd3 || d == 3'd4 || d == 3'd5;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_allow(input logic [2:0] o, input logic [2:0] d, input logic c,
                                 input logic [1:0] cp, input logic [1:0] rp,
                                 input logic [1:0] gd, input logic [1:0] td);
    logic [1:0] e;
    e = (rp > cp) ? rp : cp;
    if (!m_pair(o, d)) return 1'b0;
    if (d == 3'd1) return c ? (td <= cp) : (td == cp);
    if (d >= 3'd2 && d <= 3'd4) return (e <= gd) && (td <= cp);
    return e <= gd;
  endfunction

  function automatic logic [1:0] m_ncpl(input logic [2:0] o, input logic [2:0] d, input logic c,
                                        input logic [1:0] cp, input logic [1:0] rp,
                                        input logic [1:0] gd, input logic [1:0] td);
    if (m_allow(o, d, c, cp, rp, gd, td) && d >= 3'd2 && d <= 3'd4 && !c) return td;
    return cp;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one request and check its verdict; tag names the requirement.
  task automatic run(input string tag, input logic [2:0] o, input logic [2:0] d, input logic c,
                     input logic [1:0] cp, input logic [1:0] rp,
                     input logic [1:0] gd, input logic [1:0] td);
    bit ea;
    @(negedge clk);
    valid = 1'b1; op = o; desc = d; conf = c; cpl = cp; rpl = rp; gdpl = gd; tdpl = td;
    @(negedge clk);
    valid = 1'b0;
    ea = m_allow(o, d, c, cp, rp, gd, td);
    chk({tag, " done R1"}, done, 1);
    chk({tag, " allow"}, allow, ea);
    chk({tag, " fault R10"}, fault, !ea);
    chk({tag, " vector R10"}, vec, ea ? 0 : 13);
    chk({tag, " clear_if R7"}, clr_if, ea && d == 3'd3);
    chk({tag, " new_cpl R8"}, ncpl, m_ncpl(o, d, c, cp, rp, gd, td));
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 reset done", done, 0);
    chk("R1 reset allow", allow, 0);
    chk("R1 reset fault", fault, 0);
    chk("R1 reset vector", vec, 0);
    chk("R1 reset clear_if", clr_if, 0);
    chk("R1 reset new_cpl", ncpl, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle done", done, 0);

    // R2 pairing violations, including null and reserved
    run("R2 jmp via call gate", 3'd0, 3'd2, 0, 2'd3, 2'd3, 2'd3, 2'd0);
    run("R2 iret via int gate", 3'd3, 3'd3, 0, 2'd0, 2'd0, 2'd3, 2'd0);
    run("R2 null desc", 3'd1, 3'd0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
    run("R2 reserved op", 3'd7, 3'd1, 0, 2'd0, 2'd0, 2'd0, 2'd0);
    run("R2 reserved desc", 3'd0, 3'd7, 0, 2'd0, 2'd0, 2'd0, 2'd0);
    run("R2 pair and level both bad", 3'd2, 3'd2, 0, 2'd3, 2'd3, 2'd0, 2'd3);
    // R3 non-conforming direct
    run("R3 jmp same level", 3'd0, 3'd1, 0, 2'd2, 2'd0, 2'd0, 2'd2);
    run("R3 call inward direct", 3'd1, 3'd1, 0, 2'd3, 2'd0, 2'd0, 2'd0);
    run("R3 ret outward direct", 3'd2, 3'd1, 0, 2'd1, 2'd0, 2'd0, 2'd3);
    // R4 conforming direct
    run("R4 conf inward ok", 3'd0, 3'd1, 1, 2'd3, 2'd0, 2'd0, 2'd0);
    run("R4 conf outward bad", 3'd1, 3'd1, 1, 2'd1, 2'd0, 2'd0, 2'd2);
    // R5 gate level: edge and one past
    run("R5 eff equals gate", 3'd4, 3'd3, 0, 2'd3, 2'd1, 2'd3, 2'd0);
    run("R5 rpl too weak", 3'd1, 3'd2, 0, 2'd1, 2'd3, 2'd2, 2'd0);
    // R6 gate to outer target
    run("R6 gate target outward", 3'd1, 3'd2, 0, 2'd1, 2'd1, 2'd3, 2'd2);
    // R7/R8 interrupt gate elevates and masks in one verdict
    run("R7 R8 int gate elevate", 3'd6, 3'd3, 0, 2'd3, 2'd0, 2'd3, 2'd0);
    run("R7 trap gate keeps IF", 3'd5, 3'd4, 0, 2'd3, 2'd0, 2'd3, 2'd1);
    run("R8 gate to conforming", 3'd1, 3'd2, 1, 2'd2, 2'd0, 2'd3, 2'd0);
    // R9 task paths ignore target privilege
    run("R9 task gate outer target", 3'd0, 3'd5, 0, 2'd0, 2'd0, 2'd0, 2'd3);
    run("R9 tss low gate dpl", 3'd1, 3'd6, 0, 2'd2, 2'd0, 2'd1, 2'd0);

    // R11 outputs hold while idle
    run("R11 setup", 3'd1, 3'd2, 0, 2'd3, 2'd0, 2'd3, 2'd1);
    @(negedge clk);
    op = 3'd7; desc = 3'd0; cpl = 2'd0;
    repeat (3) @(negedge clk);
    chk("R11 hold allow", allow, 1);
    chk("R11 hold new_cpl", ncpl, 2'd1);
    chk("R11 no done", done, 0);

    // Constrained random sweep (R2..R10)
    for (int i = 0; i < 400; i++) begin
      logic [2:0] ro, rd;
      ro = 3'($urandom_range(0, 6));
      rd = 3'($urandom_range(1, 6));
      run("rand", ro, rd, 1'($urandom), 2'($urandom), 2'($urandom),
          2'($urandom), 2'($urandom));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule